// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable model of a 36-bit wide synchronous static RAM whose bus never needs an idle cycle between a read and a write. Every rising edge samples a command: clock enable, three chip enables, a load/advance control, read/write, four active-low byte-write strobes and an address. The data transfer for that command happens in the next cycle. Read data is flow-through: it comes combinationally from the array at the registered address and is valid for the whole cycle after the command. Write data and its byte strobes are taken at the edge that follows the command.

A loaded address can be continued by advance cycles. A 2-bit counter replaces the two low address bits and wraps linearly. Each advance keeps the direction that the load chose. The bidirectional data pins are split into an input bus, an output bus and an output-enable. The data bus carries no valid/ready handshake: the memory accepts a command on every enabled edge, and the only way to hold off the pipeline is to raise the clock enable pin, which freezes every register.

Top module: `zbt_sram_core`

## Requirements
- R1: The chip is selected only when `sel1_n`=0, `sel2_n`=0 and `sel3`=1. An enabled edge with `adv_ld`=0 and the chip not selected is a deselect, and `dq_oe` is 0 in the following cycle.
- R2: An enabled edge (`cen_n`=0) with the chip selected and `adv_ld`=0 loads `addr`. `we_n`=1 starts a read and `we_n`=0 starts a write.
- R3: A read puts the addressed word on `dq_out`/`dqp_out` with `dq_oe`=1 during the cycle after the command edge.
- R4: A write takes `dq_in`/`dqp_in` and `bw_n` at the enabled edge after the command edge. `dq_oe` stays 0 for that data cycle.
- R5: Byte lane n is bits [8n+7:8n] of `dq_in` plus bit n of `dqp_in`. It is written only when `bw_n[n]`=0. Any mix of lanes is allowed: all-zero strobes write the whole word and all-one strobes write nothing. On reads the strobes have no effect.
- R6: An enabled edge with `adv_ld`=1 after a load or advance increments the two low address bits, wrapping 3 to 0, and keeps the upper bits. It keeps the burst's direction and ignores `we_n` and the chip enables.
- R7: An advance after a deselect or a no-op is a no-op: `dq_oe` is 0 in the next cycle and nothing is written.
- R8: An edge with `cen_n`=1 changes nothing. The pending read keeps driving the same value, a pending write is not performed, and the burst state holds.
- R9: After reset `dq_oe` is 0 and no transfer is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Clock enable, active low |
| sel1_n | input | 1 | Chip enable, active low |
| sel2_n | input | 1 | Chip enable, active low |
| sel3 | input | 1 | Chip enable, active high |
| adv_ld | input | 1 | 1 = advance burst, 0 = load address |
| we_n | input | 1 | 0 = write, 1 = read (load cycles only) |
| bw_n | input | LANES | Byte-write strobes, active low, sampled with write data |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*8 | Write data |
| dqp_in | input | LANES | Write parity bits |
| dq_out | output | LANES*8 | Read data (zero when not driving) |
| dqp_out | output | LANES | Read parity bits (zero when not driving) |
| dq_oe | output | 1 | Output drive enable |

## Verification
The bench builds the block with `ADDR_W`=4, which gives a 16-word array. That is small enough to write and read back every word, and to sweep all sixteen byte-strobe patterns on one word. Bursts start at each low-bit offset that shows the 3-to-0 wrap, and each of the three chip enables is used to deselect. Suspend edges are placed in the middle of a pending read and a pending write. A model in the bench is written from the requirements and predicts the drive state and the data in every cycle.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;
endpackage

// File: rtl/zbt_cmd_decode.sv
module zbt_cmd_decode
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              selected,
  input  logic              adv_ld,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output phase_e            ph_kind,
  output logic [ADDR_W-1:0] ph_addr
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic live;
  logic dir_wr;
  logic [BURST_W-1:0] beat_nxt;

  assign beat_nxt = ph_addr[BURST_W-1:0] + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_kind <= PH_IDLE;
      ph_addr <= '0;
      live    <= 1'b0;
      dir_wr  <= 1'b0;
    end else if (!cen_n) begin
      if (!adv_ld) begin
        if (selected) begin
          ph_addr <= addr;
          live    <= 1'b1;
          dir_wr  <= !we_n;
          ph_kind <= we_n ? PH_READ : PH_WRITE;
        end else begin
          live    <= 1'b0;
          ph_kind <= PH_IDLE;
        end
      end else if (live) begin
        ph_addr <= {ph_addr[ADDR_W-1 -: HI_W], beat_nxt};
        ph_kind <= dir_wr ? PH_WRITE : PH_READ;
      end else begin
        ph_kind <= PH_IDLE;
      end
    end
  end

  assert_burst_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && live) |=>
      (ph_addr[BURST_W-1:0] == BURST_W'($past(ph_addr[BURST_W-1:0]) + 1'b1)) &&
      (ph_addr[ADDR_W-1 -: HI_W] == $past(ph_addr[ADDR_W-1 -: HI_W])));

  assert_burst_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && live) |=> (ph_kind == $past(ph_kind)));

  assert_adv_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && !live) |=> (ph_kind == PH_IDLE));
endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        lane_en,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [LANES*BYTE_W-1:0] wr_data,
  input  logic [LANES-1:0]        wr_par,
  output logic [LANES*BYTE_W-1:0] rd_data,
  output logic [LANES-1:0]        rd_par
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CELL_W = BYTE_W + 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CELL_W-1:0] cells [DEPTH];
    logic [CELL_W-1:0] cell_rd;

    always_ff @(posedge clk) begin
      if (wr_en && lane_en[g])
        cells[acc_addr] <= {wr_par[g], wr_data[g*BYTE_W +: BYTE_W]};
    end

    assign cell_rd = cells[acc_addr];
    assign rd_data[g*BYTE_W +: BYTE_W] = cell_rd[BYTE_W-1:0];
    assign rd_par[g] = cell_rd[BYTE_W];
  end
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cen_n,
  input  logic                sel1_n,
  input  logic                sel2_n,
  input  logic                sel3,
  input  logic                adv_ld,
  input  logic                we_n,
  input  logic [LANES-1:0]    bw_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [LANES*8-1:0]  dq_in,
  input  logic [LANES-1:0]    dqp_in,
  output logic [LANES*8-1:0]  dq_out,
  output logic [LANES-1:0]    dqp_out,
  output logic                dq_oe
);
  localparam int BYTE_W  = 8;
  localparam int BURST_W = 2;

  phase_e ph_kind;
  logic [ADDR_W-1:0] ph_addr;
  logic selected;
  logic wr_en;
  logic [LANES*BYTE_W-1:0] arr_d;
  logic [LANES-1:0] arr_p;

  assign selected = !sel1_n && !sel2_n && sel3;

  zbt_cmd_decode #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .selected(selected),
    .adv_ld(adv_ld), .we_n(we_n), .addr(addr),
    .ph_kind(ph_kind), .ph_addr(ph_addr)
  );

  assign wr_en = !cen_n && (ph_kind == PH_WRITE);

  zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_arr (
    .clk(clk), .wr_en(wr_en), .lane_en(~bw_n), .acc_addr(ph_addr),
    .wr_data(dq_in), .wr_par(dqp_in),
    .rd_data(arr_d), .rd_par(arr_p)
  );

  assign dq_oe   = (ph_kind == PH_READ);
  assign dq_out  = dq_oe ? arr_d : '0;
  assign dqp_out = dq_oe ? arr_p : '0;

  assert_deselect_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && (sel1_n || sel2_n || !sel3)) |=> !dq_oe);

  assert_load_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && !sel1_n && !sel2_n && sel3 && we_n) |=> dq_oe);

  assert_write_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && !sel1_n && !sel2_n && sel3 && !we_n) |=> !dq_oe);

  assert_suspend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(dq_oe) && $stable(dq_out) && $stable(dqp_out)));
endmodule

// File: tb/tb_zbt_sram_core.sv
module tb_zbt_sram_core;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen_n = 1'b1, sel1_n = 1'b1, sel2_n = 1'b1, sel3 = 1'b0;
  logic adv_ld = 1'b0, we_n = 1'b1;
  logic [3:0] bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [31:0] dq_in = '0;
  logic [3:0] dqp_in = '0;
  logic [31:0] dq_out;
  logic [3:0] dqp_out;
  logic dq_oe;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] ref_d [NW];
  logic [3:0]  ref_p [NW];
  int m_kind = 0;
  logic [AW-1:0] m_addr = '0;
  bit m_live = 0, m_wr = 0;

  always #5 clk = ~clk;

  zbt_sram_core #(.ADDR_W(AW), .LANES(4)) dut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sel1_n(sel1_n), .sel2_n(sel2_n),
    .sel3(sel3), .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .dq_in(dq_in), .dqp_in(dqp_in), .dq_out(dq_out), .dqp_out(dqp_out), .dq_oe(dq_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives one command at a negedge, models the edge, checks at the next negedge.
  task automatic step(input bit c, input bit s1, input bit s2, input bit s3, input bit adv,
                      input bit w, input logic [3:0] bw, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic [3:0] p, input string tag);
    cen_n = c; sel1_n = s1; sel2_n = s2; sel3 = s3; adv_ld = adv; we_n = w;
    bw_n = bw; addr = a; dq_in = d; dqp_in = p;
    @(posedge clk);
    if (!c) begin
      if (m_kind == 2)
        for (int n = 0; n < 4; n++)
          if (!bw[n]) begin
            ref_d[m_addr][8*n +: 8] = d[8*n +: 8];
            ref_p[m_addr][n] = p[n];
          end
      if (!adv) begin
        if (!s1 && !s2 && s3) begin
          m_live = 1; m_wr = !w; m_addr = a; m_kind = w ? 1 : 2;
        end else begin
          m_live = 0; m_kind = 0;
        end
      end else if (m_live) begin
        m_addr = {m_addr[AW-1:2], m_addr[1:0] + 2'd1};
        m_kind = m_wr ? 2 : 1;
      end else m_kind = 0;
    end
    @(negedge clk);
    chk(dq_oe == (m_kind == 1), {tag, " oe"}, 64'(dq_oe), 64'(m_kind == 1));
    if (m_kind == 1)
      chk({dqp_out, dq_out} == {ref_p[m_addr], ref_d[m_addr]}, {tag, " data"},
          64'({dqp_out, dq_out}), 64'({ref_p[m_addr], ref_d[m_addr]}));
  endtask

  task automatic ld(input bit w, input logic [AW-1:0] a, input logic [31:0] d,
                    input logic [3:0] p, input logic [3:0] bw, input string tag);
    step(0, 0, 0, 1, 0, w, bw, a, d, p, tag);
  endtask

  task automatic adv(input bit w, input logic [31:0] d, input logic [3:0] p, input string tag);
    step(0, 0, 0, 1, 1, w, 4'h0, '0, d, p, tag);
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'h5A3C_0F81 ^ (32'(i) * 32'h0102_0408);
  endfunction

  initial begin
    for (int i = 0; i < NW; i++) begin ref_d[i] = 'x; ref_p[i] = 'x; end
    repeat (3) @(negedge clk);
    chk(dq_oe == 1'b0, "R9 reset oe", 64'(dq_oe), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dq_oe == 1'b0, "R9 idle after reset", 64'(dq_oe), 64'd0);

    // R2 R4: fill every word, data lags its command by one edge
    for (int i = 0; i < NW; i++)
      ld(0, AW'(i), pat(i - 1), 4'(i - 1), 4'h0, "R4 fill");
    step(0, 1, 1, 0, 0, 1, 4'h0, '0, pat(NW - 1), 4'(NW - 1), "R4 last beat");
    // R3: read every word back
    for (int i = 0; i < NW; i++) ld(1, AW'(i), '0, '0, 4'h0, "R3 readback");

    // R5: every strobe pattern on word 3, read back after each
    for (int m = 0; m < 16; m++) begin
      ld(0, 4'd3, '0, '0, 4'hF, "R5 cmd");
      ld(1, 4'd3, ~pat(m + 40), 4'(m) ^ 4'hA, 4'(m), "R5 lanes");
      ld(1, 4'd3, 32'hFFFF_FFFF, 4'hF, 4'h0, "R5 strobes on read");
    end

    // R6: burst write from low bits 2, we_n high during advances
    ld(0, 4'd6, '0, '0, 4'h0, "R6 load wr");
    adv(1, 32'h1111_0001, 4'h1, "R6 adv wr");
    adv(1, 32'h2222_0002, 4'h2, "R6 adv wr");
    adv(1, 32'h3333_0003, 4'h3, "R6 adv wr wrap");
    adv(0, 32'h4444_0004, 4'h4, "R6 adv wr wrap");
    ld(1, 4'd5, 32'h5555_0005, 4'h5, 4'h0, "R6 load rd");
    for (int k = 0; k < 6; k++) adv(0, '0, '0, "R6 burst read wrap");
    ld(1, 4'd15, '0, '0, 4'h0, "R6 load rd top");
    for (int k = 0; k < 4; k++) adv(0, '0, '0, "R6 wrap top");

    // R1: each enable deselects; R7: advance afterwards is a no-op
    step(0, 1, 0, 1, 0, 1, 4'h0, 4'd2, '0, '0, "R1 sel1 off");
    step(0, 0, 0, 1, 1, 0, 4'h0, 4'd2, 32'hDEAD_BEEF, 4'hF, "R7 adv after deselect");
    step(0, 0, 0, 1, 1, 0, 4'h0, 4'd2, 32'hDEAD_BEEF, 4'hF, "R7 adv after noop");
    step(0, 0, 1, 1, 0, 0, 4'h0, 4'd2, '0, '0, "R1 sel2 off");
    step(0, 0, 0, 0, 0, 1, 4'h0, 4'd2, 32'hDEAD_BEEF, 4'hF, "R1 sel3 off");
    step(0, 0, 0, 0, 1, 0, 4'h0, 4'd2, 32'hDEAD_BEEF, 4'hF, "R7 adv ignores enables");
    for (int i = 0; i < 8; i++) ld(1, AW'(i), '0, '0, 4'h0, "R7 no stray write");
    // write then deselect still lands the data
    ld(0, 4'd8, '0, '0, 4'h0, "R1 wr before deselect");
    step(0, 1, 1, 0, 0, 1, 4'h0, '0, 32'h0BAD_F00D, 4'h9, "R1 deselect with data");
    ld(1, 4'd8, '0, '0, 4'h0, "R1 read after");

    // R8: suspend during a read and during a pending write
    ld(1, 4'd2, '0, '0, 4'h0, "R8 read");
    step(1, 0, 0, 1, 0, 1, 4'h0, 4'd9, '0, '0, "R8 suspend read");
    step(1, 1, 1, 0, 0, 0, 4'h0, 4'd9, '0, '0, "R8 suspend read again");
    ld(0, 4'd9, '0, '0, 4'h0, "R8 load wr");
    step(1, 0, 0, 1, 0, 1, 4'h0, 4'd1, 32'hCAFE_0000, 4'h0, "R8 suspend wr");
    step(0, 1, 0, 1, 0, 1, 4'hC, 4'd1, 32'h1234_5678, 4'h6, "R8 resume wr");
    ld(1, 4'd9, '0, '0, 4'h0, "R8 check");
    ld(0, 4'd10, '0, '0, 4'h0, "R8 burst");
    step(1, 0, 0, 1, 1, 1, 4'h0, '0, 32'hAAAA_AAAA, 4'h3, "R8 suspend in burst");
    adv(1, 32'h7777_7777, 4'h7, "R8 burst resume");
    adv(1, 32'h8888_8888, 4'h8, "R8 burst next");
    ld(1, 4'd10, 32'h9999_9999, 4'h9, 4'h0, "R8 rd");
    adv(0, '0, '0, "R8 rd next");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule